// File: doc/BRIEF.md
# Scratchpad-Window Memory Access Controller

This block sits between a processor's load/store (or fetch) port and two memory targets. A small on-chip scratchpad owns one contiguous, size-aligned window of the byte address space. Every other address belongs to external main memory. Each request is routed by its address alone. No tags are stored, no presence check is made, and no hit or miss indication exists: an address inside the window always goes to the scratchpad.

The block inserts wait states that depend on the target and, for main memory, on the access width. It then raises `ready` for one cycle, and in that cycle `rdata` is valid. Three saturating counters record accepted scratchpad accesses, 16-bit main-memory accesses and 32-bit main-memory accesses. A synchronous clear input zeroes all three counters.

The control is a four-state machine:
- **IDLE** accepts a request.
- **SPM_RESP** is the scratchpad response cycle.
- **MM_WAIT** counts down the main-memory wait states.
- **MM_RESP** is the main-memory response cycle.

The machine has these transitions:
- IDLE→SPM_RESP on a request whose address is in the window.
- IDLE→MM_WAIT on any other request. The wait counter is loaded with 1 for a 16-bit access and with 3 for a 32-bit access.
- MM_WAIT→MM_WAIT while the wait counter is above one, decrementing it each cycle.
- MM_WAIT→MM_RESP when the wait counter reaches one.
- SPM_RESP→IDLE and MM_RESP→IDLE unconditionally.

The requester holds its request stable until `ready` is asserted. The scratchpad size must be a power of two from 64 bytes to 2 KB, and the base must be aligned to the size.

Top module: `spm_access_ctrl`

## Requirements
- R1: A request whose address A satisfies BASE <= A < BASE+SIZE goes to the scratchpad, and `mm_req` stays low for the whole access. Any other address goes to main memory, with `mm_req` high until its response cycle ends.
- R2: A scratchpad read or write raises `ready` in the first cycle after the acceptance edge, whatever the value of `req_wide`.
- R3: A main-memory access with `req_wide`=0 (16-bit) raises `ready` in the second cycle after the acceptance edge, which is one wait state.
- R4: A main-memory access with `req_wide`=1 (32-bit) raises `ready` in the fourth cycle after the acceptance edge, which is three wait states.
- R5: `ready` is high for exactly one cycle. It is always followed by an idle cycle, and requests are accepted only in that idle state. A request held high continuously is therefore served in alternate cycles.
- R6: Scratchpad writes honour `req_be`: bit k enables byte lane k, which is bits 8k+7..8k. Disabled lanes keep their old value, and a later read returns the merged word.
- R7: While `mm_req` is high, `mm_addr`, `mm_we`, `mm_wide`, `mm_wdata` and `mm_be` equal the accepted request and stay stable. In a main-memory read's ready cycle, `rdata` equals `mm_rdata`.
- R8: At each acceptance exactly one counter increments: `cnt_spm` for a scratchpad access, `cnt_mm16` for a main access with `req_wide`=0, and `cnt_mm32` for a main access with `req_wide`=1.
- R9: A counter at its all-ones value stays there on further increments.
- R10: `cnt_clr` high at a clock edge zeroes all three counters. It takes priority over an increment in the same cycle, and it does not disturb the access being accepted.
- R11: While reset is asserted, `ready` and `mm_req` are low and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `ready` |
| req_addr | input | AW | Byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit, 0 = 16-bit access |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| ready | output | 1 | Access complete; read data valid |
| rdata | output | 32 | Read data |
| mm_req | output | 1 | Main-memory access in progress |
| mm_addr | output | AW | Main-memory byte address |
| mm_we | output | 1 | Main-memory write |
| mm_wide | output | 1 | Main-memory access width (1 = 32-bit) |
| mm_be | output | 4 | Main-memory byte enables |
| mm_wdata | output | 32 | Main-memory write data |
| mm_rdata | input | 32 | Main-memory read data |
| cnt_clr | input | 1 | Synchronous counter clear |
| cnt_spm | output | CNT_W | Scratchpad access count |
| cnt_mm16 | output | CNT_W | 16-bit main-memory access count |
| cnt_mm32 | output | CNT_W | 32-bit main-memory access count |

## Verification
The hardest situation to reach from the ports is a counter clear that lands on the very edge where a request is accepted, and a counter that is already pinned at its maximum. The bench narrows the counter width to four bits. It issues seventeen scratchpad accesses to reach saturation. It then presents a new request and `cnt_clr` in the same idle cycle, so both act on one edge. The window edges are probed with the last word below the base, the base itself, the last word inside, and the first word past the end.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SPM_RESP = 2'd1,
        ST_MM_WAIT  = 2'd2,
        ST_MM_RESP  = 2'd3
    } ctl_state_e;

    localparam int NUM_CNT  = 3;
    localparam int CNT_SPM  = 0;
    localparam int CNT_MM16 = 1;
    localparam int CNT_MM32 = 2;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;

endpackage

// File: rtl/spm_region_decode.sv
module spm_region_decode #(
    parameter int             AW       = 32,
    parameter int             SPM_SIZE = 2048,
    parameter logic [AW-1:0]  SPM_BASE = 32'h0001_0000
) (
    input  logic [AW-1:0] addr,
    output logic          in_window
);
    localparam int OFS_W = $clog2(SPM_SIZE);

    // Base is size-aligned, so membership is an equality on the upper bits.
    always_comb begin
        in_window = (addr[AW-1:OFS_W] == SPM_BASE[AW-1:OFS_W]);
    end

endmodule

// File: rtl/spm_ram.sv
module spm_ram
    import spm_pkg::*;
#(
    parameter int WORDS = 512
) (
    input  logic                      clk,
    input  logic                      en,
    input  logic                      we,
    input  logic [LANES-1:0]          be,
    input  logic [$clog2(WORDS)-1:0]  addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata
);
    logic [LANES-1:0][7:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int k = 0; k < LANES; k++) begin
                    if (be[k]) begin
                        mem[addr][k] <= wdata[8*k +: 8];
                    end
                end
            end
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/spm_ctl_fsm.sv
module spm_ctl_fsm
    import spm_pkg::*;
#(
    parameter int WAIT16 = 1,
    parameter int WAIT32 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic in_window,
    input  logic req_wide,
    output logic accept,
    output logic ready,
    output logic from_spm,
    output logic mm_busy
);
    localparam int WCW = $clog2(WAIT32 + 1);

    ctl_state_e     state_q, state_d;
    logic [WCW-1:0] wcnt_q, wcnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (in_window) begin
                        state_d = ST_SPM_RESP;
                    end else begin
                        state_d = ST_MM_WAIT;
                        wcnt_d  = req_wide ? WCW'(WAIT32) : WCW'(WAIT16);
                    end
                end
            end
            ST_SPM_RESP: state_d = ST_IDLE;
            ST_MM_WAIT: begin
                if (wcnt_q <= WCW'(1)) begin
                    state_d = ST_MM_RESP;
                    wcnt_d  = '0;
                end else begin
                    wcnt_d = wcnt_q - WCW'(1);
                end
            end
            ST_MM_RESP: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept   = 1'b0;
        ready    = 1'b0;
        from_spm = 1'b0;
        mm_busy  = 1'b0;
        unique case (state_q)
            ST_IDLE:     accept = req_valid;
            ST_SPM_RESP: begin
                ready    = 1'b1;
                from_spm = 1'b1;
            end
            ST_MM_WAIT:  mm_busy = 1'b1;
            ST_MM_RESP: begin
                ready   = 1'b1;
                mm_busy = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spm_sat_counter.sv
module spm_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CNT_MAX)) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spm_access_ctrl.sv
module spm_access_ctrl
    import spm_pkg::*;
#(
    parameter int             AW       = 32,
    parameter int             SPM_SIZE = 2048,
    parameter logic [AW-1:0]  SPM_BASE = 32'h0001_0000,
    parameter int             WAIT16   = 1,
    parameter int             WAIT32   = 3,
    parameter int             CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_we,
    input  logic              req_wide,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              ready,
    output logic [31:0]       rdata,
    output logic              mm_req,
    output logic [AW-1:0]     mm_addr,
    output logic              mm_we,
    output logic              mm_wide,
    output logic [3:0]        mm_be,
    output logic [31:0]       mm_wdata,
    input  logic [31:0]       mm_rdata,
    input  logic              cnt_clr,
    output logic [CNT_W-1:0]  cnt_spm,
    output logic [CNT_W-1:0]  cnt_mm16,
    output logic [CNT_W-1:0]  cnt_mm32
);
    localparam int OFS_W = $clog2(SPM_SIZE);
    localparam int WORDS = SPM_SIZE / 4;
    localparam int IDX_W = OFS_W - 2;

    logic              hit;
    logic              accept;
    logic              from_spm;
    logic              mm_busy;
    logic [31:0]       ram_rdata;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]  cnt_val [NUM_CNT];

    logic [AW-1:0]     lat_addr;
    logic              lat_we;
    logic              lat_wide;
    logic [3:0]        lat_be;
    logic [31:0]       lat_wdata;

    spm_region_decode #(
        .AW       (AW),
        .SPM_SIZE (SPM_SIZE),
        .SPM_BASE (SPM_BASE)
    ) u_decode (
        .addr      (req_addr),
        .in_window (hit)
    );

    spm_ctl_fsm #(
        .WAIT16 (WAIT16),
        .WAIT32 (WAIT32)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .in_window (hit),
        .req_wide  (req_wide),
        .accept    (accept),
        .ready     (ready),
        .from_spm  (from_spm),
        .mm_busy   (mm_busy)
    );

    spm_ram #(
        .WORDS (WORDS)
    ) u_ram (
        .clk   (clk),
        .en    (accept && hit),
        .we    (req_we),
        .be    (req_be),
        .addr  (req_addr[OFS_W-1:2]),
        .wdata (req_wdata),
        .rdata (ram_rdata)
    );

    // Capture the request for the main-memory side at acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_we    <= 1'b0;
            lat_wide  <= 1'b0;
            lat_be    <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_we    <= req_we;
            lat_wide  <= req_wide;
            lat_be    <= req_be;
            lat_wdata <= req_wdata;
        end
    end

    always_comb begin
        mm_req   = mm_busy;
        mm_addr  = lat_addr;
        mm_we    = lat_we && mm_busy;
        mm_wide  = lat_wide;
        mm_be    = lat_be;
        mm_wdata = lat_wdata;
    end

    always_comb begin
        if (!ready)        rdata = '0;
        else if (from_spm) rdata = ram_rdata;
        else               rdata = mm_rdata;
    end

    always_comb begin
        cnt_inc           = '0;
        cnt_inc[CNT_SPM]  = accept && hit;
        cnt_inc[CNT_MM16] = accept && !hit && !req_wide;
        cnt_inc[CNT_MM32] = accept && !hit && req_wide;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        spm_sat_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (cnt_inc[g]),
            .count (cnt_val[g])
        );
    end

    assign cnt_spm  = cnt_val[CNT_SPM];
    assign cnt_mm16 = cnt_val[CNT_MM16];
    assign cnt_mm32 = cnt_val[CNT_MM32];

    // Index width is referenced so a bad size shows up as a width mismatch.
    logic [IDX_W-1:0] unused_idx;
    assign unused_idx = req_addr[OFS_W-1:2];

endmodule

// File: rtl/spm_access_chk.sv
module spm_access_chk #(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             accept,
    input logic             hit,
    input logic             ready,
    input logic             mm_req,
    input logic [AW-1:0]    mm_addr,
    input logic             cnt_clr,
    input logic [CNT_W-1:0] cnt_spm,
    input logic [CNT_W-1:0] cnt_mm16,
    input logic [CNT_W-1:0] cnt_mm32
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    // R5
    ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R5
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !ready);

    // R2
    spm_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> ready);

    // R1
    spm_no_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> !mm_req);

    // R3, R4
    main_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit) |=> (!ready && mm_req));

    // R7
    main_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_req && $past(mm_req)) |-> $stable(mm_addr));

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_spm == '0 && cnt_mm16 == '0 && cnt_mm32 == '0));

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_spm == CMAX && !cnt_clr) |=> (cnt_spm == CMAX));

endmodule

bind spm_access_ctrl spm_access_chk #(
    .AW    (AW),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .hit      (hit),
    .ready    (ready),
    .mm_req   (mm_req),
    .mm_addr  (mm_addr),
    .cnt_clr  (cnt_clr),
    .cnt_spm  (cnt_spm),
    .cnt_mm16 (cnt_mm16),
    .cnt_mm32 (cnt_mm32)
);

// File: tb/tb_spm_access_ctrl.sv
module tb_spm_access_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 32;
    localparam int SIZE  = 256;
    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam int CW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic req_we = 1'b0;
    logic req_wide = 1'b0;
    logic [3:0] req_be = '0;
    logic [31:0] req_wdata = '0;
    logic ready;
    logic [31:0] rdata;
    logic mm_req, mm_we, mm_wide;
    logic [31:0] mm_addr, mm_wdata, mm_rdata;
    logic [3:0] mm_be;
    logic cnt_clr = 1'b0;
    logic [CW-1:0] cnt_spm, cnt_mm16, cnt_mm32;

    int checks = 0;
    int errors = 0;
    logic [31:0] mm_mem [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    spm_access_ctrl #(
        .AW(AW), .SPM_SIZE(SIZE), .SPM_BASE(BASE), .CNT_W(CW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_we(req_we), .req_wide(req_wide), .req_be(req_be), .req_wdata(req_wdata),
        .ready(ready), .rdata(rdata), .mm_req(mm_req), .mm_addr(mm_addr),
        .mm_we(mm_we), .mm_wide(mm_wide), .mm_be(mm_be), .mm_wdata(mm_wdata),
        .mm_rdata(mm_rdata), .cnt_clr(cnt_clr), .cnt_spm(cnt_spm),
        .cnt_mm16(cnt_mm16), .cnt_mm32(cnt_mm32)
    );

    function automatic logic [31:0] mm_init(input int i);
        return 32'hA500_0000 | (i * 32'h0000_0101);
    endfunction

    assign mm_rdata = mm_mem[mm_addr[7:2]];

    always @(posedge clk) begin
        if (mm_req && mm_we) begin
            for (int k = 0; k < 4; k++)
                if (mm_be[k]) mm_mem[mm_addr[7:2]][8*k +: 8] <= mm_wdata[8*k +: 8];
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic do_access(input logic [31:0] a, input bit we, input bit wide,
                             input logic [31:0] wd, input logic [3:0] be,
                             output logic [31:0] rd, output int lat, output bit saw_mm);
        req_addr = a; req_we = we; req_wide = wide; req_wdata = wd; req_be = be;
        req_valid = 1'b1;
        lat = 0; saw_mm = 1'b0;
        do begin
            @(negedge clk);
            lat++;
            if (mm_req) saw_mm = 1'b1;
        end while (!ready && lat < 20);
        rd = rdata;
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
    endtask

    task automatic t_reset();
        // R11
        chk(ready == 1'b0, "R11 ready in reset", 32'(ready), 0);
        chk(mm_req == 1'b0, "R11 mm_req in reset", 32'(mm_req), 0);
        chk(cnt_spm == 0 && cnt_mm16 == 0 && cnt_mm32 == 0, "R11 counters in reset",
            32'({cnt_spm, cnt_mm16, cnt_mm32}), 0);
    endtask

    task automatic t_window_and_latency();
        logic [31:0] rd; int lat; bit sm;
        // R1 R2: base of window, scratchpad write then read, both widths
        do_access(BASE, 1'b1, 1'b1, 32'h1357_9BDF, 4'hF, rd, lat, sm);
        chk(lat == 1, "R2 spm write latency", 32'(lat), 1);
        chk(!sm, "R1 base no mm_req", 32'(sm), 0);
        do_access(BASE, 1'b0, 1'b0, 0, 4'hF, rd, lat, sm);
        chk(lat == 1, "R2 spm 16-bit read latency", 32'(lat), 1);
        chk(rd == 32'h1357_9BDF, "R1 spm readback", rd, 32'h1357_9BDF);
        // R1: last word inside
        do_access(BASE + SIZE - 4, 1'b0, 1'b1, 0, 4'hF, rd, lat, sm);
        chk(!sm && lat == 1, "R1 last word inside window", 32'(lat), 1);
        // R1 R4: word just below
        do_access(BASE - 4, 1'b0, 1'b1, 0, 4'hF, rd, lat, sm);
        chk(sm, "R1 below window uses main", 32'(sm), 1);
        chk(lat == 4, "R4 32-bit main latency", 32'(lat), 4);
        chk(rd == mm_init(63), "R7 main read data", rd, mm_init(63));
        // R1 R3: first word past end
        do_access(BASE + SIZE, 1'b0, 1'b0, 0, 4'h3, rd, lat, sm);
        chk(sm, "R1 past window uses main", 32'(sm), 1);
        chk(lat == 2, "R3 16-bit main latency", 32'(lat), 2);
        chk(rd == mm_init(0), "R7 main read data idx0", rd, mm_init(0));
    endtask

    task automatic t_spm_bytes();
        logic [31:0] rd; int lat; bit sm;
        // R6: lane k = bits 8k+7..8k
        do_access(BASE + 16, 1'b1, 1'b1, 32'h1122_3344, 4'hF, rd, lat, sm);
        do_access(BASE + 16, 1'b1, 1'b1, 32'hAABB_CCDD, 4'b0101, rd, lat, sm);
        do_access(BASE + 16, 1'b0, 1'b1, 0, 4'hF, rd, lat, sm);
        chk(rd == 32'h11BB_33DD, "R6 byte-enable merge", rd, 32'h11BB_33DD);
        do_access(BASE + 16, 1'b1, 1'b0, 32'h0000_EE00, 4'b0010, rd, lat, sm);
        do_access(BASE + 16, 1'b0, 1'b1, 0, 4'hF, rd, lat, sm);
        chk(rd == 32'h11BB_EEDD, "R6 single-lane write", rd, 32'h11BB_EEDD);
    endtask

    task automatic t_main_forward();
        logic [31:0] rd; int lat; bit sm;
        // R7: outputs carry the request while mm_req is high
        req_addr = 32'h48; req_we = 1'b1; req_wide = 1'b1;
        req_wdata = 32'hCAFE_F00D; req_be = 4'hF; req_valid = 1'b1;
        @(negedge clk);
        chk(mm_req && mm_addr == 32'h48 && mm_we && mm_wide, "R7 main ctl forward",
            mm_addr, 32'h48);
        chk(mm_wdata == 32'hCAFE_F00D && mm_be == 4'hF, "R7 main data forward",
            mm_wdata, 32'hCAFE_F00D);
        while (!ready) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!mm_req, "R7 mm_req drops after response", 32'(mm_req), 0);
        do_access(32'h48, 1'b0, 1'b1, 0, 4'hF, rd, lat, sm);
        chk(rd == 32'hCAFE_F00D, "R7 main write then read", rd, 32'hCAFE_F00D);
        do_access(32'h44, 1'b1, 1'b0, 32'h0000_BEEF, 4'b0011, rd, lat, sm);
        do_access(32'h44, 1'b0, 1'b1, 0, 4'hF, rd, lat, sm);
        chk(rd == {mm_init(17)[31:16], 16'hBEEF}, "R7 16-bit main write lanes",
            rd, {mm_init(17)[31:16], 16'hBEEF});
    endtask

    task automatic t_back_to_back();
        bit exp_r;
        // R5: held request served in alternate cycles
        req_addr = BASE + 8; req_we = 1'b0; req_wide = 1'b1; req_be = 4'hF;
        req_valid = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            exp_r = (k % 2) == 1;
            chk(ready == exp_r, "R5 ready alternation", 32'(ready), 32'(exp_r));
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_counters();
        logic [31:0] rd; int lat; bit sm;
        pulse_clear();
        chk(cnt_spm == 0 && cnt_mm16 == 0 && cnt_mm32 == 0, "R10 clear zeroes",
            32'({cnt_spm, cnt_mm16, cnt_mm32}), 0);
        // R8
        do_access(BASE + 4, 1'b0, 1'b1, 0, 4'hF, rd, lat, sm);
        do_access(BASE + 8, 1'b1, 1'b0, 1, 4'h3, rd, lat, sm);
        do_access(32'h20, 1'b0, 1'b0, 0, 4'h3, rd, lat, sm);
        do_access(32'h24, 1'b0, 1'b1, 0, 4'hF, rd, lat, sm);
        do_access(32'h28, 1'b1, 1'b1, 5, 4'hF, rd, lat, sm);
        do_access(32'h2C, 1'b0, 1'b1, 0, 4'hF, rd, lat, sm);
        chk(cnt_spm == 2, "R8 scratchpad count", 32'(cnt_spm), 2);
        chk(cnt_mm16 == 1, "R8 16-bit main count", 32'(cnt_mm16), 1);
        chk(cnt_mm32 == 3, "R8 32-bit main count", 32'(cnt_mm32), 3);
    endtask

    task automatic t_saturate_and_clear();
        logic [31:0] rd; int lat; bit sm;
        pulse_clear();
        // R9
        for (int i = 0; i < 17; i++)
            do_access(BASE + 32, 1'b0, 1'b1, 0, 4'hF, rd, lat, sm);
        chk(cnt_spm == 4'hF, "R9 saturation at max", 32'(cnt_spm), 32'hF);
        chk(cnt_mm16 == 0 && cnt_mm32 == 0, "R8 other counters untouched",
            32'({cnt_mm16, cnt_mm32}), 0);
        // R10: clear on the acceptance edge wins, access still served
        req_addr = BASE + 32; req_we = 1'b0; req_wide = 1'b1; req_valid = 1'b1;
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        chk(cnt_spm == 0, "R10 clear beats increment", 32'(cnt_spm), 0);
        chk(ready == 1'b1, "R10 access served during clear", 32'(ready), 1);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mm_mem[i] = mm_init(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_window_and_latency();
        t_spm_bytes();
        t_main_forward();
        t_back_to_back();
        t_counters();
        t_saturate_and_clear();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule